// File: doc/BRIEF.md
# Table-Sequenced Floppy Read/Write Engine

This block is the bit engine between a floppy drive head and a processor. It runs on a 2 MHz clock. A four-bit state register, together with the transfer direction, a shift-or-load select, the top bit of the data latch and a read pulse, addresses a 256-entry lookup table. The read pulse is already synchronised to the sequencer clock. Each table byte holds two fields. The upper nibble is the next state. The lower nibble is a command that acts on an eight-bit data latch. The engine has no dedicated shifter or deserialiser. The table alone serialises bytes for writing and assembles bytes from head pulses for reading.

When writing, the processor places a byte on a parallel bus. The engine loads it into the latch and moves it out MSB first, one bit per eight clocks (4 µs). The write pulse output is the top bit of the state register. If the processor does not reload in time, zeros move out. This is how self-synchronising gaps are made. When reading, head pulses become 1 bits and missing pulses become 0 bits. A byte whose MSB is 1 is held in the latch so that the processor can poll it. The latch is then cleared and the next byte is built.

Top module: `disk_seq`

## Requirements
- R1: While reset is active, and for the first two clock edges after it is released, the latch reads 0x00 and the write pulse is 0. The state register starts at 0.
- R2: The write pulse output always equals bit 3 of the state register, one cycle after the table entry that set that state.
- R3: In write mode (write_mode=1), states other than x7 step to state+1. The latch is untouched except in states 2 and 10 with load_sel=0: there the latch moves one place toward the MSB and a 0 enters bit 0.
- R4: In write mode with load_sel=1, states 2 and 10 copy cpu_data into the latch and step to states 3 and 11.
- R5: In write mode, state 7 goes to state 0 when latch bit 7 is 0 and to state 8 when it is 1. State 15 goes to state 8 when latch bit 7 is 0 and to state 0 when it is 1.
- R6: In read mode (write_mode=0) with load_sel=1, every state goes to state 0. The latch moves one place toward bit 0, and wprot enters bit 7.
- R7: In read mode with load_sel=0 and latch bit 7 clear, the engine behaves as follows. State 0 goes to state 1. State 1 shifts a 1 into bit 0 and goes to state 2. A pulse seen in states 2 to 9 sends it to state 13. State 13 with no pulse returns to state 0. State 9 with no pulse shifts a 0 into bit 0 and goes to state 2. The remaining entries follow the read-shift table.
- R8: In read mode with load_sel=0 and latch bit 7 set, state 12 with no pulse clears the latch and goes to state 10. State 15 clears the latch and goes to state 14. State 2 with no pulse stays in state 2.
- R9: In read mode with load_sel=0, once latch bit 7 is 1, the next latch value is either unchanged or 0x00.
- R10: In write mode, rd_pulse and wprot have no effect on the latch or on the write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| write_mode | input | 1 | 1 = write direction, 0 = read direction |
| load_sel | input | 1 | 1 = load/sense select, 0 = shift select |
| rd_pulse | input | 1 | Head flux pulse, already synchronised to clk |
| wprot | input | 1 | Write-protect sense bit |
| cpu_data | input | 8 | Parallel byte from the processor |
| latch_q | output | 8 | Data latch contents |
| wr_pulse | output | 1 | Write pulse (state bit 3) |

## Verification
The state register and the latch are the only registers on the data path. Every input applied before a rising edge therefore shows on latch_q and wr_pulse right after that edge. Reset release adds two edges, because the internal reset goes through two synchroniser flops. The bench changes inputs at a falling edge and steps its own table model at that moment. At the next falling edge it compares both outputs, so each comparison lands exactly one rising edge after its stimulus. During the reset-release window it expects zeros for two falling edges before stepping the model.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  localparam int unsigned STATE_W = 4;
  localparam int unsigned CMD_W   = 4;
  localparam int unsigned ENTRY_W = STATE_W + CMD_W;

  // latch commands carried in the low nibble of a table entry
  typedef enum logic [CMD_W-1:0] {
    CMD_CLR = 4'h0,
    CMD_NOP = 4'h8,
    CMD_SL0 = 4'h9,
    CMD_SRW = 4'hA,
    CMD_LDB = 4'hB,
    CMD_SL1 = 4'hD
  } cmd_e;

  typedef struct packed {
    logic [STATE_W-1:0] nxt;
    cmd_e               cmd;
  } entry_t;

  typedef struct packed {
    logic [STATE_W-1:0] state;
    logic               wr;
    logic               ld;
    logic               msb;
    logic               pulse;
  } addr_t;

  function automatic entry_t pack_entry(input logic [ENTRY_W-1:0] raw);
    entry_t e;
    e.nxt = raw[ENTRY_W-1:CMD_W];
    e.cmd = cmd_e'(raw[CMD_W-1:0]);
    return e;
  endfunction

endpackage

// File: rtl/dsq_rst_sync.sv
module dsq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/dsq_rom.sv
module dsq_rom
  import dsq_pkg::*;
(
  input  addr_t  addr,
  output entry_t ent
);

  logic [ENTRY_W-1:0] rd_raw;
  entry_t             wr_ent;
  entry_t             rd_ent;

  // write direction: a count of eight with a branch at x7 and a bit action at x2
  always_comb begin
    wr_ent.nxt = addr.state + {{(STATE_W-1){1'b0}}, 1'b1};
    wr_ent.cmd = CMD_NOP;
    if (addr.state[2:0] == 3'd2) begin
      wr_ent.cmd = addr.ld ? CMD_LDB : CMD_SL0;
    end
    if (addr.state[2:0] == 3'd7) begin
      wr_ent.nxt = {addr.msb ^ addr.state[STATE_W-1], {(STATE_W-1){1'b0}}};
    end
  end

  // read direction with shift select: entries chosen by state, latch msb and pulse
  always_comb begin
    rd_raw = 8'h18;
    unique case (addr.state)
      4'h0: rd_raw = 8'h18;
      4'h1: rd_raw = addr.msb ? 8'h38 : 8'h2D;
      4'h2: rd_raw = addr.msb ? (addr.pulse ? 8'h08 : 8'h28) : (addr.pulse ? 8'hD8 : 8'h38);
      4'h3: rd_raw = (!addr.msb && addr.pulse) ? 8'hD8 : 8'h48;
      4'h4: rd_raw = addr.pulse ? 8'hD8 : 8'h58;
      4'h5: rd_raw = addr.pulse ? 8'hD8 : 8'h68;
      4'h6: rd_raw = addr.pulse ? 8'hD8 : 8'h78;
      4'h7: rd_raw = addr.pulse ? 8'hD8 : 8'h88;
      4'h8: rd_raw = addr.pulse ? 8'hD8 : 8'h98;
      4'h9: rd_raw = addr.pulse ? 8'hD8 : (addr.msb ? 8'hA8 : 8'h29);
      4'hA: rd_raw = addr.msb ? (addr.pulse ? 8'hD8 : 8'hB8) : (addr.pulse ? 8'hCD : 8'hBD);
      4'hB: rd_raw = addr.msb ? (addr.pulse ? 8'hD8 : 8'hC8) : (addr.pulse ? 8'hD9 : 8'h59);
      4'hC: rd_raw = addr.msb ? (addr.pulse ? 8'hD8 : 8'hA0) : 8'hD9;
      4'hD: rd_raw = addr.msb ? 8'hE8 : (addr.pulse ? 8'hD8 : 8'h08);
      4'hE: rd_raw = addr.msb ? 8'hF8 : 8'hFD;
      4'hF: rd_raw = addr.msb ? 8'hE0 : (addr.pulse ? 8'hDD : 8'h4D);
      default: rd_raw = 8'h18;
    endcase
    rd_ent = pack_entry(rd_raw);
  end

  always_comb begin
    if (addr.wr) begin
      ent = wr_ent;
    end else if (addr.ld) begin
      ent.nxt = '0;
      ent.cmd = CMD_SRW;
    end else begin
      ent = rd_ent;
    end
  end

endmodule

// File: rtl/dsq_state.sv
module dsq_state #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= '0;
    end else if (en) begin
      q_r <= d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/dsq_latch.sv
module dsq_latch
  import dsq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  cmd_e              cmd,
  input  logic [DATA_W-1:0] bus,
  input  logic              wp,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] d;
  logic              en;

  always_comb begin
    en = (cmd != CMD_NOP);
    d  = q_r;
    unique case (cmd)
      CMD_CLR: d = '0;
      CMD_SL0: d = {q_r[DATA_W-2:0], 1'b0};
      CMD_SL1: d = {q_r[DATA_W-2:0], 1'b1};
      CMD_LDB: d = bus;
      CMD_SRW: d = {wp, q_r[DATA_W-1:1]};
      default: d = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= '0;
    end else if (en) begin
      q_r <= d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/disk_seq.sv
module disk_seq
  import dsq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              write_mode,
  input  logic              load_sel,
  input  logic              rd_pulse,
  input  logic              wprot,
  input  logic [DATA_W-1:0] cpu_data,
  output logic [DATA_W-1:0] latch_q,
  output logic              wr_pulse
);

  localparam logic [STATE_W-1:0] ONE_ST = {{(STATE_W-1){1'b0}}, 1'b1};

  logic               rst_sn;
  logic [STATE_W-1:0] state_q;
  logic               state_en;
  addr_t              rom_addr;
  entry_t             rom_ent;

  dsq_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  always_comb begin
    rom_addr.state = state_q;
    rom_addr.wr    = write_mode;
    rom_addr.ld    = load_sel;
    rom_addr.msb   = latch_q[DATA_W-1];
    rom_addr.pulse = rd_pulse;
    state_en       = 1'b1;
  end

  dsq_rom u_rom (
    .addr (rom_addr),
    .ent  (rom_ent)
  );

  dsq_state #(.W(STATE_W)) u_state (
    .clk    (clk),
    .rst_ni (rst_sn),
    .en     (state_en),
    .d      (rom_ent.nxt),
    .q      (state_q)
  );

  dsq_latch #(.DATA_W(DATA_W)) u_latch (
    .clk    (clk),
    .rst_ni (rst_sn),
    .cmd    (rom_ent.cmd),
    .bus    (cpu_data),
    .wp     (wprot),
    .q      (latch_q)
  );

  assign wr_pulse = state_q[STATE_W-1];

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_sn)
    write_mode && (state_q[2:0] != 3'd7) |=> state_q == $past(state_q) + ONE_ST); // R3
  AST_WR_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    write_mode && (state_q[2:0] != 3'd2) |=> $stable(latch_q)); // R10
  AST_WR_LOAD_BUS: assert property (@(posedge clk) disable iff (!rst_sn)
    write_mode && load_sel && (state_q[2:0] == 3'd2) |=> latch_q == $past(cpu_data)); // R4
  AST_WR_SEVEN_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    write_mode && (state_q == 4'h7) && !latch_q[DATA_W-1] |=> state_q == 4'h0); // R5
  AST_WR_FIFTEEN_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    write_mode && (state_q == 4'hF) && !latch_q[DATA_W-1] |=> state_q == 4'h8); // R5
  AST_RD_SENSE: assert property (@(posedge clk) disable iff (!rst_sn)
    !write_mode && load_sel |=> (state_q == '0)
      && (latch_q == {$past(wprot), $past(latch_q[DATA_W-1:1])})); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !write_mode && !load_sel && latch_q[DATA_W-1]
      |=> (latch_q == $past(latch_q)) || (latch_q == '0)); // R9
  AST_RD_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_sn)
    !write_mode && !load_sel && !latch_q[DATA_W-1] && (state_q == 4'hD) && !rd_pulse
      |=> state_q == 4'h0); // R7

endmodule

// File: tb/sim_disk_seq.sv
`timescale 1ns/1ps
module sim_disk_seq;

  localparam int CLK_PERIOD = 500;
  localparam int WATCH_CYC  = 200000;

  logic       clk;
  logic       rst_n;
  logic       write_mode;
  logic       load_sel;
  logic       rd_pulse;
  logic       wprot;
  logic [7:0] cpu_data;
  logic [7:0] latch_q;
  logic       wr_pulse;

  int  n_chk;
  int  n_bad;
  bit  done;
  logic [3:0] ms;
  logic [7:0] ml;
  logic [7:0] ml_prev;
  string      tag;

  disk_seq u0 (
    .clk(clk), .rst_n(rst_n), .write_mode(write_mode), .load_sel(load_sel),
    .rd_pulse(rd_pulse), .wprot(wprot), .cpu_data(cpu_data),
    .latch_q(latch_q), .wr_pulse(wr_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // read-shift table rows: bytes for (msb0,pulse) (msb0,none) (msb1,pulse) (msb1,none)
  function automatic logic [31:0] rs_row(input logic [3:0] s);
    case (s)
      4'h0: return 32'h18181818;  4'h1: return 32'h2D2D3838;
      4'h2: return 32'hD8380828;  4'h3: return 32'hD8484848;
      4'h4: return 32'hD858D858;  4'h5: return 32'hD868D868;
      4'h6: return 32'hD878D878;  4'h7: return 32'hD888D888;
      4'h8: return 32'hD898D898;  4'h9: return 32'hD829D8A8;
      4'hA: return 32'hCDBDD8B8;  4'hB: return 32'hD959D8C8;
      4'hC: return 32'hD9D9D8A0;  4'hD: return 32'hD808E8E8;
      4'hE: return 32'hFDFDF8F8;  default: return 32'hDD4DE0E0;
    endcase
  endfunction

  function automatic logic [7:0] ref_entry(input logic [3:0] s, input logic w,
                                           input logic l, input logic m, input logic p);
    logic [31:0] row;
    logic [1:0]  col;
    logic [3:0]  nx;
    if (w) begin
      nx = s + 4'd1;
      if (s == 4'h7) nx = m ? 4'h8 : 4'h0;
      if (s == 4'hF) nx = m ? 4'h0 : 4'h8;
      if (s == 4'h2 || s == 4'hA) return {nx, l ? 4'hB : 4'h9};
      return {nx, 4'h8};
    end
    if (l) return 8'h0A;
    row = rs_row(s);
    col = {m, ~p};
    return row[31 - 8*col -: 8];
  endfunction

  function automatic logic [7:0] ref_latch(input logic [3:0] c, input logic [7:0] v,
                                           input logic [7:0] b, input logic wp);
    case (c)
      4'h0: return 8'h00;
      4'h9: return {v[6:0], 1'b0};
      4'hD: return {v[6:0], 1'b1};
      4'hB: return b;
      4'hA: return {wp, v[7:1]};
      default: return v;
    endcase
  endfunction

  function automatic string pick_tag(input logic [3:0] s, input logic w, input logic l,
                                     input logic m, input logic p, input logic wp);
    if (w) begin
      if (s[2:0] == 3'd7) return "R5";
      if (s[2:0] == 3'd2) return l ? "R4" : "R3";
      if (p || wp) return "R10";
      return "R3";
    end
    if (l) return "R6";
    if (m) return "R8";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // drive inputs, step the model, compare one rising edge later
  task automatic cycle(input logic w, input logic l, input logic p,
                       input logic wp, input logic [7:0] b);
    logic [7:0] e;
    write_mode = w; load_sel = l; rd_pulse = p; wprot = wp; cpu_data = b;
    tag = pick_tag(ms, w, l, ml[7], p, wp);
    e = ref_entry(ms, w, l, ml[7], p);
    ml_prev = ml;
    ml = ref_latch(e[3:0], ml, b, wp);
    ms = e[7:4];
    @(negedge clk);
    check(tag, latch_q, ml);
    check("R2", {7'd0, wr_pulse}, {7'd0, ms[3]});
    if (!w && !l && ml_prev[7])
      check("R9", {7'd0, (latch_q == ml_prev) || (latch_q == 8'h00)}, 8'h01);
  endtask

  task automatic send_byte(input logic [7:0] v, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      for (int k = 0; k < 8; k++) cycle(1'b0, 1'b0, (k == 0) && v[i], 1'b0, 8'h00);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCH_CYC);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    n_chk = 0; n_bad = 0; done = 1'b0;
    seed = $urandom(32'h5EED_2024);
    rst_n = 1'b0; write_mode = 1'b0; load_sel = 1'b0; rd_pulse = 1'b0;
    wprot = 1'b0; cpu_data = 8'h00;
    ms = 4'h0; ml = 8'h00; ml_prev = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", latch_q, 8'h00);
    check("R1", {7'd0, wr_pulse}, 8'h00);
    // busy inputs during reset must not move anything
    write_mode = 1'b1; load_sel = 1'b1; cpu_data = 8'hFF;
    @(negedge clk);
    check("R1", latch_q, 8'h00);
    write_mode = 1'b0; load_sel = 1'b0; cpu_data = 8'h00;
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check("R1", latch_q, 8'h00);
      check("R1", {7'd0, wr_pulse}, 8'h00);
    end

    // write: load a byte, then let it move out and zeros follow (R3 R4 R5)
    for (int i = 0; i < 16; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, 8'hA5);
    for (int i = 0; i < 80; i++) cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 16; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    // read-sense: write-protect bits enter at the top (R6)
    for (int i = 0; i < 12; i++) cycle(1'b0, 1'b1, 1'b0, i[0], 8'h00);
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    // read-shift: sync runs then a header pattern (R7 R8 R9)
    send_byte(8'hFF, 7);
    send_byte(8'h00, 2);
    for (int r = 0; r < 4; r++) begin
      send_byte(8'hFF, 8);
      send_byte(8'h00, 2);
    end
    send_byte(8'hD5, 8);
    send_byte(8'hAA, 8);
    send_byte(8'h96, 8);
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      logic w, l, p, wp;
      logic [7:0] b;
      w  = ($urandom % 3) == 0;
      l  = w ? (($urandom % 4) == 0) : (($urandom % 16) == 0);
      p  = ($urandom % 8) == 0;
      wp = $urandom % 2;
      b  = 8'($urandom);
      cycle(w, l, p, wp, b);
    end
    finish_run();
  end

endmodule